// File: doc/BRIEF.md
# Flash Block Erase Command Controller

This block sits on the device side of a flash memory's write bus and handles the block erase path. Bus writes are decoded as command bytes. A setup byte followed by a confirm byte starts an erase of the block named by the upper address bits of the confirm write. Before the erase starts, the block checks an external lock flag and a programming-supply-valid flag. A parameterised down-counter stands in for the erase itself, and a test input can force the erase to fail.

A status byte is returned on the read port whenever the block is in status mode. Its error bits are sticky. Several erases can run back to back and the accumulated result can be checked once at the end, because only the clear command resets those bits. A read-array command switches the read port back to the array word. The array itself lies outside this block, so that word is a fixed parameter value here.

The controller has three states:
- `ST_IDLE` waits for commands.
- `ST_SETUP` has received the setup byte and waits for the confirm.
- `ST_ERASE` runs the busy count.

The transitions are:
- **arm**: `ST_IDLE` → `ST_SETUP`, on write 0x20.
- **launch**: `ST_SETUP` → `ST_ERASE`, on write 0xD0 with the block unlocked and the supply good.
- **reject**: `ST_SETUP` → `ST_IDLE`, on a confirm refused for lock or supply, or on any other byte.
- **finish**: `ST_ERASE` → `ST_IDLE`, when the count expires.

Top module: `flash_erase_ctl`

## Requirements
- R1: After reset the block is in read-array mode: `status_mode` is 0, `rd_data` equals `ARRAY_WORD` (0xFF by default), and the internal status value is 0x80.
- R2: A write of 0x20 followed by a write of 0xD0 starts an erase. From the cycle after the confirm, status bit 7 reads 0 for exactly `ERASE_CYCLES` cycles, then reads 1. `erase_block` shows the top `BLK_W` address bits of the confirm write.
- R3: A confirm while `blk_locked` is high does not erase (bit 7 stays 1) and sets status bits 1 and 5.
- R4: A confirm while `vpp_ok` is low does not erase and sets bits 3 and 5. If `vpp_ok` is low in any cycle of a running erase, bits 3 and 5 are set when that erase ends.
- R5: Any byte other than 0xD0 written after 0x20, including 0xFF, sets bits 4 and 5 and returns to idle in status mode.
- R6: `fail_force` high in the last cycle of an erase sets bit 5. It has no effect in earlier cycles.
- R7: Error bits stay set across later successful erases.
- R8: A write of 0x50 in idle clears bits 1, 3, 4 and 5. It leaves bit 7 and the read mode unchanged.
- R9: A write of 0xFF in idle selects read-array mode. A write of 0x20, and every setup outcome, selects status mode.
- R10: Writes during an erase have no effect. In idle, bytes other than 0x20, 0x50 and 0xFF have no effect.
- R11: Status bits 0, 2 and 6 always read 0. The layout is bit 7 ready, bit 5 erase error, bit 4 sequence error, bit 3 supply error, bit 1 lock error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | 8 | Command byte |
| blk_locked | input | 1 | Lock flag of the addressed block, sampled at confirm |
| vpp_ok | input | 1 | Programming supply within range |
| fail_force | input | 1 | Forces failure when high in the last erase cycle |
| rd_data | output | 8 | Status byte or array word, depending on mode |
| status_mode | output | 1 | 1 when reads return status |
| erase_block | output | BLK_W | Block latched at the last launched erase |

## Verification
Every command takes effect at the clock edge that samples its write. Mode changes, error bits and the clearing of bit 7 at launch are therefore visible at the falling edge right after the write. The bench drives each write over one full cycle from a falling edge and samples at the next falling edge. For an erase, the ready bit is sampled at each of the `ERASE_CYCLES`+1 falling edges after the confirm. It must be 0 at the first `ERASE_CYCLES` of them and 1 at the last. The injected supply drops and forced failures are swept across every cycle of the erase window, and the cycle in which each one counts follows from that same edge count.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ERASE
    } fe_state_e;

    typedef enum logic [2:0] {
        CMD_OTHER,
        CMD_SETUP,
        CMD_CONFIRM,
        CMD_CLEAR,
        CMD_ARRAY
    } fe_cmd_e;

    localparam logic [7:0] BYTE_SETUP   = 8'h20;
    localparam logic [7:0] BYTE_CONFIRM = 8'hD0;
    localparam logic [7:0] BYTE_CLEAR   = 8'h50;
    localparam logic [7:0] BYTE_ARRAY   = 8'hFF;

    localparam int SB_READY = 7;
    localparam int SB_FAIL  = 5;
    localparam int SB_SEQ   = 4;
    localparam int SB_VPP   = 3;
    localparam int SB_LOCK  = 1;

endpackage

// File: rtl/fe_cmd_decode.sv
module fe_cmd_decode
    import flash_erase_pkg::*;
(
    input  logic [7:0] data,
    output fe_cmd_e    cmd
);

    always_comb begin
        unique case (data)
            BYTE_SETUP:   cmd = CMD_SETUP;
            BYTE_CONFIRM: cmd = CMD_CONFIRM;
            BYTE_CLEAR:   cmd = CMD_CLEAR;
            BYTE_ARRAY:   cmd = CMD_ARRAY;
            default:      cmd = CMD_OTHER;
        endcase
    end

endmodule

// File: rtl/fe_busy_timer.sv
module fe_busy_timer #(
    parameter int CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);

    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = run && (cnt_q == '0);

    // R2: a count just loaded may not expire in the next cycle unless CYCLES is 1
    a_r2_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done || CYCLES == 1));

endmodule

// File: rtl/fe_status_reg.sv
module fe_status_reg
    import flash_erase_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ready,
    input  logic       set_lock,
    input  logic       set_vpp,
    input  logic       set_seq,
    input  logic       set_fail,
    input  logic       clr,
    output logic [7:0] status
);

    logic lock_q, vpp_q, seq_q, fail_q;
    logic any_err;

    assign any_err = set_lock | set_vpp | set_seq | set_fail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            vpp_q  <= 1'b0;
            seq_q  <= 1'b0;
            fail_q <= 1'b0;
        end else if (clr) begin
            lock_q <= 1'b0;
            vpp_q  <= 1'b0;
            seq_q  <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            lock_q <= lock_q | set_lock;
            vpp_q  <= vpp_q  | set_vpp;
            seq_q  <= seq_q  | set_seq;
            fail_q <= fail_q | any_err;
        end
    end

    always_comb begin
        status           = 8'h00;
        status[SB_READY] = ready;
        status[SB_FAIL]  = fail_q;
        status[SB_SEQ]   = seq_q;
        status[SB_VPP]   = vpp_q;
        status[SB_LOCK]  = lock_q;
    end

    // R7: the failure bit holds until a clear
    a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[SB_FAIL] && !clr) |=> status[SB_FAIL]);

    // R8: a clear with no new error leaves all error bits low
    a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !any_err) |=> (status[5:1] == 5'b0));

endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl
    import flash_erase_pkg::*;
#(
    parameter int         ADDR_W       = 21,
    parameter int         BLK_W        = 6,
    parameter int         ERASE_CYCLES = 4096,
    parameter logic [7:0] ARRAY_WORD   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              blk_locked,
    input  logic              vpp_ok,
    input  logic              fail_force,
    output logic [7:0]        rd_data,
    output logic              status_mode,
    output logic [BLK_W-1:0]  erase_block
);

    localparam int BLK_LSB = ADDR_W - BLK_W;

    fe_state_e state_q, state_d;
    fe_cmd_e   cmd;
    logic      mode_q, mode_d;
    logic      vpp_bad_q;
    logic      start, tmr_done;
    logic      set_lock, set_vpp, set_seq, set_fail, clr;
    logic [7:0] status;

    fe_cmd_decode u_dec (
        .data (bus_wdata),
        .cmd  (cmd)
    );

    fe_busy_timer #(.CYCLES(ERASE_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .run   (state_q == ST_ERASE),
        .done  (tmr_done)
    );

    fe_status_reg u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ready    (state_q != ST_ERASE),
        .set_lock (set_lock),
        .set_vpp  (set_vpp),
        .set_seq  (set_seq),
        .set_fail (set_fail),
        .clr      (clr),
        .status   (status)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            mode_q      <= 1'b0;
            vpp_bad_q   <= 1'b0;
            erase_block <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            if (start) begin
                vpp_bad_q   <= 1'b0;
                erase_block <= bus_addr[ADDR_W-1:BLK_LSB];
            end else if (state_q == ST_ERASE && !vpp_ok) begin
                vpp_bad_q <= 1'b1;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        mode_d   = mode_q;
        start    = 1'b0;
        set_lock = 1'b0;
        set_vpp  = 1'b0;
        set_seq  = 1'b0;
        set_fail = 1'b0;
        clr      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_we) begin
                    unique case (cmd)
                        CMD_SETUP: begin
                            state_d = ST_SETUP;
                            mode_d  = 1'b1;
                        end
                        CMD_CLEAR: clr    = 1'b1;
                        CMD_ARRAY: mode_d = 1'b0;
                        default: ;
                    endcase
                end
            end
            ST_SETUP: begin
                if (bus_we) begin
                    mode_d  = 1'b1;
                    state_d = ST_IDLE;
                    if (cmd != CMD_CONFIRM) begin
                        set_seq = 1'b1;
                    end else if (blk_locked) begin
                        set_lock = 1'b1;
                    end else if (!vpp_ok) begin
                        set_vpp = 1'b1;
                    end else begin
                        start   = 1'b1;
                        state_d = ST_ERASE;
                    end
                end
            end
            ST_ERASE: begin
                if (tmr_done) begin
                    state_d  = ST_IDLE;
                    set_vpp  = vpp_bad_q | ~vpp_ok;
                    set_fail = fail_force;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign status_mode = mode_q;
    assign rd_data     = mode_q ? status : ARRAY_WORD;

    // R3: a locked confirm returns to idle with the lock bit set
    a_r3_lock_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && state_q == ST_SETUP && cmd == CMD_CONFIRM && blk_locked)
        |=> (state_q == ST_IDLE && status[SB_LOCK] && status[SB_READY]));

    // R2: the ready bit returns as soon as the count expires
    a_r2_ready_after: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE && tmr_done) |=> status[SB_READY]);

    // R9: read-array command in idle selects the array word
    a_r9_array_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && state_q == ST_IDLE && cmd == CMD_ARRAY) |=> !status_mode);

    // R10: no write disturbs the error bits or mode while erasing
    a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE && !tmr_done)
        |=> ($stable(status[5:1]) && $stable(status_mode)));

endmodule

// File: tb/test_flash_erase_ctl.sv
module test_flash_erase_ctl;

    localparam int AW = 8;
    localparam int BW = 3;
    localparam int N  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          locked = 1'b0;
    logic          vpp = 1'b1;
    logic          fail = 1'b0;
    logic [7:0]    rd;
    logic          smode;
    logic [BW-1:0] blk;

    int checks = 0;
    int errors = 0;

    always #4ns clk = ~clk;

    flash_erase_ctl #(.ADDR_W(AW), .BLK_W(BW), .ERASE_CYCLES(N), .ARRAY_WORD(8'hFF)) i_flash_erase_ctl (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
        .blk_locked(locked), .vpp_ok(vpp), .fail_force(fail),
        .rd_data(rd), .status_mode(smode), .erase_block(blk)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // one-cycle write launched at a falling edge; returns at the following falling edge
    task automatic wr(input logic [7:0] d);
        we    = 1'b1;
        wdata = d;
        @(negedge clk);
        we    = 1'b0;
    endtask

    // status byte from its fields; bits 0, 2 and 6 are zero
    function automatic int st(input bit ready, input bit lk, input bit vp, input bit sq, input bit fl);
        return (ready << 7) | (fl << 5) | (sq << 4) | (vp << 3) | (lk << 1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 mode", smode, 0);
        check("R1 rd", rd, 8'hFF);
        wr(8'h20);
        wr(8'h50);
        wr(8'h50);
        check("R1 status", rd, st(1, 0, 0, 0, 0));
        wr(8'hFF);

        // R10: idle sweep leaves array mode intact
        for (int d = 0; d < 256; d++) begin
            if (d == 8'h20) continue;
            wr(8'(d));
            check("R10 idle mode", smode, 0);
            check("R10 idle rd", rd, 8'hFF);
        end

        // R2: normal erase with ready timing and block capture
        addr = 8'b101_10011;
        wr(8'h20);
        check("R9 setup mode", smode, 1);
        check("R11 setup status", rd, st(1, 0, 0, 0, 0));
        wr(8'hD0);
        for (int i = 0; i <= N; i++) begin
            check("R2 ready bit", rd, (i < N) ? st(0, 0, 0, 0, 0) : st(1, 0, 0, 0, 0));
            if (i < N) @(negedge clk);
        end
        check("R2 block", blk, 3'b101);

        // R5: every broken sequence byte
        for (int d = 0; d < 256; d++) begin
            if (d == 8'hD0) continue;
            wr(8'h20);
            wr(8'(d));
            check("R5 R11 seq error", rd, st(1, 0, 0, 1, 1));
            check("R5 mode", smode, 1);
            wr(8'h50);
            check("R8 clear", rd, st(1, 0, 0, 0, 0));
        end

        // R3: locked block
        locked = 1'b1;
        wr(8'h20);
        wr(8'hD0);
        check("R3 lock refused", rd, st(1, 1, 0, 0, 1));
        @(negedge clk);
        check("R3 no busy", rd, st(1, 1, 0, 0, 1));
        locked = 1'b0;
        // R7: sticky across a good erase
        wr(8'h20);
        wr(8'hD0);
        check("R7 busy keeps errors", rd, st(0, 1, 0, 0, 1));
        repeat (N) @(negedge clk);
        check("R7 sticky", rd, st(1, 1, 0, 0, 1));

        // R10: writes during erase ignored
        wr(8'h20);
        wr(8'hD0);
        wr(8'h50);
        wr(8'hFF);
        wr(8'h20);
        repeat (N) @(negedge clk);
        check("R10 busy writes", rd, st(1, 1, 0, 0, 1));
        check("R10 busy mode", smode, 1);
        wr(8'hD0);
        check("R10 stray confirm", rd, st(1, 1, 0, 0, 1));
        wr(8'h50);
        check("R8 clear after lock", rd, st(1, 0, 0, 0, 0));

        // R4: supply bad at confirm
        vpp = 1'b0;
        wr(8'h20);
        wr(8'hD0);
        check("R4 vpp refused", rd, st(1, 0, 1, 0, 1));
        vpp = 1'b1;
        wr(8'h50);

        // R4: supply drop swept over the erase window
        for (int j = 0; j <= N; j++) begin
            wr(8'h20);
            wr(8'hD0);
            repeat (j) @(negedge clk);
            vpp = 1'b0;
            @(negedge clk);
            vpp = 1'b1;
            repeat (N + 2) @(negedge clk);
            check("R4 vpp during erase", rd, (j < N) ? st(1, 0, 1, 0, 1) : st(1, 0, 0, 0, 0));
            wr(8'h50);
        end

        // R6: forced failure swept over the erase window
        for (int j = 0; j <= N; j++) begin
            wr(8'h20);
            wr(8'hD0);
            repeat (j) @(negedge clk);
            fail = 1'b1;
            @(negedge clk);
            fail = 1'b0;
            repeat (N + 2) @(negedge clk);
            check("R6 forced fail", rd, (j == N - 1) ? st(1, 0, 0, 0, 1) : st(1, 0, 0, 0, 0));
            wr(8'h50);
        end

        // R9 and R8: array mode, clear does not change mode
        wr(8'h20);
        wr(8'h11);
        wr(8'hFF);
        check("R9 array", smode, 0);
        check("R9 array rd", rd, 8'hFF);
        wr(8'h50);
        check("R8 mode kept", smode, 0);
        wr(8'h20);
        check("R8 cleared in array mode", rd, st(1, 0, 0, 0, 0));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule